// File: doc/BRIEF.md
# Multicore Reset Controller Register Block

This block is the register front end of the reset logic for a four-core processor cluster. Software reaches a small bank of 32-bit registers through a word-addressed bus that decodes a 4 KiB window. One of these registers is the control register. Writing it can power secondary cores 1 to 3 on or off, issue timed reset pulses to any of the four cores, and issue one-cycle reset pulses to two image-processing peripherals. The other registers are plain storage. Three pairs of them hold the start address and start argument that each secondary core picks up when it is powered on.

A control write acts only on the bits whose new value differs from the stored one. An enable change drives the matching core's power level and, on power-on, captures that core's start address and argument. A reset-bit change starts a fixed-length pulse, and the bit drops by itself once the pulse is over. Peripheral reset bits are never stored. Accesses outside the implemented registers, and accesses that are not word-aligned, are rejected and flagged.

Top module: `rstctl_regs`

## Requirements
- R1: After reset, the register at index 0 (control, byte offset 0x00) reads 0x521, index 2 (offset 0x08) reads 0x1, index 4 (offset 0x10) reads 0x1F, and every other register reads 0. All power, pulse and error outputs are low.
- R2: A read of an aligned in-range byte offset 4*i returns the value stored in register i. The value appears on `bus_rdata` after the clock edge that samples the read.
- R3: An access with byte offset bits [1:0] not zero, or with word index offset>>2 of NUM_REGS or more, raises `bus_err` for the one cycle after the access. Such a read returns 0, and such a write changes no register.
- R4: A write to any in-range register other than index 0 stores the written value and changes no output other than later read data.
- R5: A control write acts only on the bits that differ from the stored value. Writing back the stored value produces no pulse and no power change.
- R6: Bits 22, 23 and 24 of the control register are the enables of cores 1, 2 and 3. `core_power` bit k-1 follows the enable of core k. A 0-to-1 change copies register 6+2k into `boot_addr` slice k-1 and register 7+2k into `boot_arg` slice k-1, and both slices hold that value until the next enabling write of that core.
- R7: When a core's enable changes, that core's reset bit is not handled as a reset request in the same write, so no reset pulse is produced. Its stored reset bit still clears on the fifth edge after the write.
- R8: Bits 13 to 16 are the reset requests of cores 0 to 3. A change in bit 13+k drives `core_rst_pulse[k]` high for exactly PULSE_CYCLES (4) cycles after the write edge. The bit reads back as written until it clears on edge PULSE_CYCLES+1 after the write.
- R9: Bits 3 and 12 are the reset requests of peripherals 0 and 1. A change in either drives `periph_rst_pulse[0]` or `periph_rst_pulse[1]` high for the one cycle after the write, and both bits always read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W (12) | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | Rejected access, registered |
| core_power | output | 3 | Power level of cores 1 to 3 |
| core_rst_pulse | output | 4 | Timed reset pulse of cores 0 to 3 |
| periph_rst_pulse | output | 2 | One-cycle peripheral reset pulses |
| boot_addr | output | 96 | Captured start address, 32 bits per secondary core |
| boot_arg | output | 96 | Captured start argument, 32 bits per secondary core |

## Verification
Read data, the error flag, power levels, captured start values and peripheral pulses are all due one edge after the access. The bench therefore samples them at the falling edge that follows the access edge. A core reset pulse is sampled at each of the next eight falling edges and its high samples are counted against four. Self-clearing is checked by reading the control register once right after the request, when the bit must still be set, and again after six idle cycles, by which time it must have cleared.

// File: rtl/rstctl_pkg.sv
// Shared constants for the reset controller register block: register
// indices, reset values and the control-register bit layout.
// Assumes 32-bit registers and a four-core cluster with cores 1..3 switchable.
package rstctl_pkg;

    localparam int REG_W   = 32;
    localparam int CORES   = 4;
    localparam int PERIPHS = 2;

    localparam int IDX_CTRL     = 0;
    localparam int IDX_STATUS   = 2;
    localparam int IDX_IMASK    = 4;
    localparam int IDX_SCRATCH1 = 6;

    localparam logic [REG_W-1:0] CTRL_INIT   = 32'h0000_0521;
    localparam logic [REG_W-1:0] STATUS_INIT = 32'h0000_0001;
    localparam logic [REG_W-1:0] IMASK_INIT  = 32'h0000_001F;

    localparam int CORE_RST_LSB = 13;
    localparam int CORE_EN_LSB  = 22;

    // Control bit of the enable of secondary core 'core' (1..3)
    function automatic int en_bit(input int core);
        return CORE_EN_LSB + core - 1;
    endfunction

    // Control bit of the reset request of peripheral 'p'
    function automatic int periph_bit(input int p);
        return (p == 0) ? 3 : 12;
    endfunction

    // Register holding the start address of secondary core 'core'
    function automatic int entry_index(input int core);
        return IDX_SCRATCH1 + 2 * core;
    endfunction

    // Register holding the start argument of secondary core 'core'
    function automatic int arg_index(input int core);
        return IDX_SCRATCH1 + 2 * core + 1;
    endfunction

    // Value a register takes on reset
    function automatic logic [REG_W-1:0] init_value(input int idx);
        case (idx)
            IDX_CTRL:   return CTRL_INIT;
            IDX_STATUS: return STATUS_INIT;
            IDX_IMASK:  return IMASK_INIT;
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/rstctl_decode.sv
// Address decoder: turns a byte offset into a word index and says whether
// the access targets an implemented register with an aligned address.
// Assumes NUM_REGS fits in the window of ADDR_W bytes.
module rstctl_decode #(
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = 12,
    parameter int IDX_W    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              hit
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;

    // Word index is the byte offset without its two low bits
    assign word = addr[ADDR_W-1:2];
    // Hit when aligned and inside the implemented bank
    assign hit  = (addr[1:0] == 2'b00) && (int'(word) < NUM_REGS);
    assign idx  = word[IDX_W-1:0];

endmodule

// File: rtl/rstctl_regfile.sv
// Plain storage registers of the bank. The control slot is left empty here
// and held by the control unit; each other slot loads on a matching write.
// Assumes the caller only raises 'we' for in-range, non-control indices.
module rstctl_regfile
    import rstctl_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] regs [NUM_REGS]
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        if (i == IDX_CTRL) begin : g_ctrl_gap
            // Control register lives in the control unit
            assign regs[i] = '0;
        end else begin : g_store
            // Load slot i on reset value or matching write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[i] <= init_value(i);
                end else if (we && (widx == IDX_W'(i))) begin
                    regs[i] <= wdata;
                end
            end
        end
    end

endmodule

// File: rtl/rstctl_pulse.sv
// Per-core reset sequencer: on start it runs a PULSE_CYCLES countdown,
// drives the reset pulse during it when the start was a reset request,
// and asks for the control bit to clear in the cycle after the countdown.
// Assumes a new start simply restarts the sequence.
module rstctl_pulse #(
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic fire,
    output logic rst_pulse,
    output logic clr
);
    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    logic             pend;
    logic             firing;

    // Countdown and pending-clear state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            pend   <= 1'b0;
            firing <= 1'b0;
        end else if (start) begin
            cnt    <= CNT_W'(PULSE_CYCLES);
            pend   <= 1'b1;
            firing <= fire;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else if (pend) begin
            pend <= 1'b0;
        end
    end

    // Pulse only while counting and only for a reset request
    assign rst_pulse = firing && (cnt != '0);
    // Clear request in the first idle cycle after the countdown
    assign clr       = pend && (cnt == '0);

endmodule

// File: rtl/rstctl_ctrl.sv
// Control register and its write side effects. A write is compared with
// the stored value; changed enables switch power and capture start values,
// changed core reset bits start a sequence, changed peripheral bits pulse
// once and are never stored. Changes are taken in a fixed order: enables of
// cores 3, 2, 1, then core resets 0..3, then peripheral resets. An enable
// change consumes that core's reset bit for the same write.
module rstctl_ctrl
    import rstctl_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [REG_W-1:0]            wdata,
    input  logic [REG_W-1:0]            entry_in [CORES-1],
    input  logic [REG_W-1:0]            arg_in   [CORES-1],
    input  logic [CORES-1:0]            clr_req,
    output logic [REG_W-1:0]            ctrl_q,
    output logic [CORES-1:0]            seq_start,
    output logic [CORES-1:0]            seq_fire,
    output logic [CORES-2:0]            core_power,
    output logic [(CORES-1)*REG_W-1:0]  boot_addr,
    output logic [(CORES-1)*REG_W-1:0]  boot_arg,
    output logic [PERIPHS-1:0]          periph_pulse
);
    logic [REG_W-1:0] chg;
    logic [REG_W-1:0] wval;
    logic [REG_W-1:0] ctrl_d;
    logic [CORES-1:0] en_chg;
    logic [CORES-1:0] rst_chg;

    // Change detection, ordered side effects and next control value
    always_comb begin
        chg     = ctrl_q ^ wdata;
        en_chg  = '0;
        rst_chg = '0;
        for (int k = CORES - 1; k >= 1; k--) begin
            en_chg[k] = chg[en_bit(k)];
        end
        for (int k = 0; k < CORES; k++) begin
            rst_chg[k] = chg[CORE_RST_LSB + k] && !en_chg[k];
        end
        wval = wdata;
        for (int p = 0; p < PERIPHS; p++) begin
            wval[periph_bit(p)] = 1'b0;
        end
        ctrl_d = we ? wval : ctrl_q;
        for (int k = 0; k < CORES; k++) begin
            if (clr_req[k] && !(we && (en_chg[k] || rst_chg[k]))) begin
                ctrl_d[CORE_RST_LSB + k] = 1'b0;
            end
        end
    end

    // Sequencer launch: enable or reset change starts, only reset fires
    assign seq_start = {CORES{we}} & (en_chg | rst_chg);
    assign seq_fire  = {CORES{we}} & rst_chg;

    // Control register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_INIT;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // One-cycle peripheral reset pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            periph_pulse <= '0;
        end else begin
            for (int p = 0; p < PERIPHS; p++) begin
                periph_pulse[p] <= we && chg[periph_bit(p)];
            end
        end
    end

    // Power levels are the stored enable bits
    for (genvar k = 1; k < CORES; k++) begin : g_power
        assign core_power[k-1] = ctrl_q[en_bit(k)];
    end

    // Capture start address and argument on each enabling write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_addr <= '0;
            boot_arg  <= '0;
        end else begin
            for (int k = 1; k < CORES; k++) begin
                if (we && en_chg[k] && wdata[en_bit(k)]) begin
                    boot_addr[(k-1)*REG_W +: REG_W] <= entry_in[k-1];
                    boot_arg[(k-1)*REG_W +: REG_W]  <= arg_in[k-1];
                end
            end
        end
    end

endmodule

// File: rtl/rstctl_regs.sv
// Top of the reset controller register block: bus decode, storage bank,
// control unit and one reset sequencer per core. Reads and error flags are
// registered and valid the cycle after the access.
// Assumes one access per cycle and NUM_REGS large enough for the start
// address and argument registers of every secondary core.
module rstctl_regs
    import rstctl_pkg::*;
#(
    parameter int NUM_REGS     = 16,
    parameter int PULSE_CYCLES = 4,
    parameter int ADDR_W       = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_write,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [REG_W-1:0]           bus_wdata,
    output logic [REG_W-1:0]           bus_rdata,
    output logic                       bus_err,
    output logic [CORES-2:0]           core_power,
    output logic [CORES-1:0]           core_rst_pulse,
    output logic [PERIPHS-1:0]         periph_rst_pulse,
    output logic [(CORES-1)*REG_W-1:0] boot_addr,
    output logic [(CORES-1)*REG_W-1:0] boot_arg
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic [IDX_W-1:0] idx;
    logic             hit;
    logic             wr_gen;
    logic             wr_ctrl;
    logic [REG_W-1:0] regs [NUM_REGS];
    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] entry_vals [CORES-1];
    logic [REG_W-1:0] arg_vals   [CORES-1];
    logic [CORES-1:0] seq_start;
    logic [CORES-1:0] seq_fire;
    logic [CORES-1:0] clr_req;
    logic [REG_W-1:0] rd_val;

    rstctl_decode #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W)
    ) u_decode (
        .addr (bus_addr),
        .idx  (idx),
        .hit  (hit)
    );

    // Split accepted writes between control unit and storage bank
    assign wr_ctrl = bus_sel && bus_write && hit && (idx == IDX_W'(IDX_CTRL));
    assign wr_gen  = bus_sel && bus_write && hit && (idx != IDX_W'(IDX_CTRL));

    rstctl_regfile #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_gen),
        .widx  (idx),
        .wdata (bus_wdata),
        .regs  (regs)
    );

    // Fixed start address and argument pair per secondary core
    for (genvar k = 1; k < CORES; k++) begin : g_entry
        assign entry_vals[k-1] = regs[entry_index(k)];
        assign arg_vals[k-1]   = regs[arg_index(k)];
    end

    rstctl_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (wr_ctrl),
        .wdata        (bus_wdata),
        .entry_in     (entry_vals),
        .arg_in       (arg_vals),
        .clr_req      (clr_req),
        .ctrl_q       (ctrl_q),
        .seq_start    (seq_start),
        .seq_fire     (seq_fire),
        .core_power   (core_power),
        .boot_addr    (boot_addr),
        .boot_arg     (boot_arg),
        .periph_pulse (periph_rst_pulse)
    );

    for (genvar k = 0; k < CORES; k++) begin : g_seq
        rstctl_pulse #(
            .PULSE_CYCLES (PULSE_CYCLES)
        ) u_pulse (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (seq_start[k]),
            .fire      (seq_fire[k]),
            .rst_pulse (core_rst_pulse[k]),
            .clr       (clr_req[k])
        );
    end

    // Read source: control unit or storage bank
    assign rd_val = (idx == IDX_W'(IDX_CTRL)) ? ctrl_q : regs[idx];

    // Registered read data and access error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_err <= bus_sel && !hit;
            if (bus_sel && !bus_write) begin
                bus_rdata <= hit ? rd_val : '0;
            end
        end
    end

endmodule

// File: rtl/rstctl_regs_chk.sv
// Checker bound to the top: relates bus activity to flags, pulses and
// power changes. Purely observational.
module rstctl_regs_chk
    import rstctl_pkg::*;
#(
    parameter int NUM_REGS     = 16,
    parameter int PULSE_CYCLES = 4,
    parameter int ADDR_W       = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_write,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [REG_W-1:0]           bus_wdata,
    input logic [REG_W-1:0]           bus_rdata,
    input logic                       bus_err,
    input logic [CORES-2:0]           core_power,
    input logic [CORES-1:0]           core_rst_pulse,
    input logic [PERIPHS-1:0]         periph_rst_pulse,
    input logic [(CORES-1)*REG_W-1:0] boot_addr,
    input logic [(CORES-1)*REG_W-1:0] boot_arg
);
    localparam int RUN_W = $clog2(PULSE_CYCLES + 2);

    logic bad;
    logic ctrl_wr;

    assign bad     = (bus_addr[1:0] != 2'b00) || (int'(bus_addr[ADDR_W-1:2]) >= NUM_REGS);
    assign ctrl_wr = bus_sel && bus_write && (bus_addr == '0);

    // R3: error only after a rejected access
    assert_err_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel && bad));

    // R3: rejected read yields zero
    assert_bad_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_write && bad) |=> (bus_rdata == '0));

    // R6: power changes only after a control write
    assert_power_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(core_power) |-> $past(ctrl_wr));

    // R9: peripheral pulses only after a control write
    assert_periph_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|periph_rst_pulse) |-> $past(ctrl_wr));

    // R9: peripheral bits never read back set
    assert_periph_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_write && (bus_addr == '0)) |=>
        (bus_rdata[periph_bit(0)] == 1'b0 && bus_rdata[periph_bit(1)] == 1'b0));

    for (genvar k = 0; k < CORES; k++) begin : g_core
        logic [RUN_W-1:0] run;

        // Length of the current pulse, restarted by a control write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run <= '0;
            end else if (core_rst_pulse[k] && !ctrl_wr) begin
                run <= run + 1'b1;
            end else begin
                run <= '0;
            end
        end

        // R8: pulse starts only after a control write
        assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(core_rst_pulse[k]) |-> $past(ctrl_wr));

        // R8: pulse never outlasts its length
        assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
            core_rst_pulse[k] |-> (int'(run) < PULSE_CYCLES));
    end

endmodule

bind rstctl_regs rstctl_regs_chk #(
    .NUM_REGS     (NUM_REGS),
    .PULSE_CYCLES (PULSE_CYCLES),
    .ADDR_W       (ADDR_W)
) u_chk (.*);

// File: tb/rstctl_regs_tb.sv
module rstctl_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 16;
    localparam int AW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [2:0]  core_power;
    logic [3:0]  core_rst_pulse;
    logic [1:0]  periph_rst_pulse;
    logic [95:0] boot_addr;
    logic [95:0] boot_arg;

    int n_tests = 0;
    int n_fail = 0;
    logic [31:0] model [NREG];
    logic [31:0] cur;
    logic [31:0] rd;

    rstctl_regs u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] init_val(input int i);
        case (i)
            0: return 32'h521;
            2: return 32'h1;
            4: return 32'h1F;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic is_bad(input logic [11:0] a);
        return (a[1:0] != 2'b00) || (int'(a[11:2]) >= NREG);
    endfunction

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        logic [11:0] a;
        logic [31:0] d;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of outputs and registers
        check("R1 power", core_power, 0);
        check("R1 pulses", {core_rst_pulse, periph_rst_pulse}, 0);
        check("R1 err", bus_err, 0);
        for (int i = 0; i < NREG; i++) begin
            model[i] = init_val(i);
            do_read(12'(i * 4), rd);
            check("R1 reset value", rd, init_val(i));
        end

        // R2 R3 R4: random accesses against the model
        for (int i = 0; i < 300; i++) begin
            a = 12'(($urandom % 24) * 4);
            if ($urandom % 8 == 0) a = a | 12'($urandom % 3 + 1);
            if ($urandom % 16 == 0) a = 12'hFFC;
            d = $urandom;
            if (($urandom % 2 == 0) && !(a == 12'h0)) begin
                do_write(a, d);
                if (!is_bad(a)) model[a[5:2]] = d;
                check("R3 write err", bus_err, is_bad(a));
                check("R4 no side effect", {core_power, core_rst_pulse, periph_rst_pulse}, 0);
            end else begin
                do_read(a, rd);
                if (is_bad(a)) check("R3 bad read zero", rd, 0);
                else check("R2 read data", rd, model[a[5:2]]);
                check("R3 read err", bus_err, is_bad(a));
            end
        end
        for (int i = 1; i < NREG; i++) begin
            do_read(12'(i * 4), rd);
            check("R4 stored value", rd, model[i]);
        end
        do_read(12'h0, rd);
        check("R3 ctrl untouched", rd, 32'h521);
        cur = 32'h521;

        // R5: rewriting the stored value does nothing
        do_write(12'h0, cur);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            if ({core_power, core_rst_pulse, periph_rst_pulse} != 0) cnt++;
            @(negedge clk);
        end
        check("R5 no action", cnt, 0);

        // R8: core 2 reset pulse length
        do_write(12'h0, cur | (32'h1 << 15));
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            if (core_rst_pulse == 4'b0100) cnt++;
            else check("R8 other cores quiet", core_rst_pulse, 0);
            @(negedge clk);
        end
        check("R8 pulse length", cnt, 4);
        do_read(12'h0, rd);
        check("R8 bit self-cleared", rd, cur);

        // R8: core 0 bit reads set then clears
        do_write(12'h0, cur | (32'h1 << 13));
        check("R8 pulse starts", core_rst_pulse, 4'b0001);
        do_read(12'h0, rd);
        check("R8 bit still set", rd, cur | (32'h1 << 13));
        repeat (6) @(negedge clk);
        do_read(12'h0, rd);
        check("R8 bit cleared later", rd, cur);

        // R9: peripheral pulses and readback
        do_write(12'h0, cur | (32'h1 << 3) | (32'h1 << 12));
        check("R9 both pulses", periph_rst_pulse, 2'b11);
        @(negedge clk);
        check("R9 one cycle", periph_rst_pulse, 2'b00);
        do_read(12'h0, rd);
        check("R9 reads zero", rd, cur);
        do_write(12'h0, cur | (32'h1 << 12));
        check("R9 peripheral 1 only", periph_rst_pulse, 2'b10);

        // R6: enable core 1 and core 3, capture start values
        do_write(12'h20, 32'hCAFE_0001); model[8] = 32'hCAFE_0001;
        do_write(12'h24, 32'h0000_00A1); model[9] = 32'h0000_00A1;
        do_write(12'h30, 32'hBEEF_0003); model[12] = 32'hBEEF_0003;
        do_write(12'h34, 32'h0000_00A3); model[13] = 32'h0000_00A3;
        cur = cur | (32'h1 << 22);
        do_write(12'h0, cur);
        check("R6 core1 power", core_power, 3'b001);
        check("R6 core1 addr", boot_addr[31:0], model[8]);
        check("R6 core1 arg", boot_arg[31:0], model[9]);
        check("R6 no reset pulse", core_rst_pulse, 0);
        cur = cur | (32'h1 << 24);
        do_write(12'h0, cur);
        check("R6 core3 power", core_power, 3'b101);
        check("R6 core3 addr", boot_addr[95:64], model[12]);
        check("R6 core3 arg", boot_arg[95:64], model[13]);
        do_write(12'h20, 32'h1234_5678); model[8] = 32'h1234_5678;
        do_write(12'h0, cur);
        check("R5 R6 held addr", boot_addr[31:0], 32'hCAFE_0001);
        cur = cur & ~(32'h1 << 22);
        do_write(12'h0, cur);
        check("R6 core1 off", core_power, 3'b100);
        check("R6 addr kept", boot_addr[31:0], 32'hCAFE_0001);

        // R7: enable change swallows the same core's reset request
        do_write(12'h0, cur | (32'h1 << 23) | (32'h1 << 15));
        cur = cur | (32'h1 << 23);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            if (core_rst_pulse != 0) cnt++;
            @(negedge clk);
        end
        check("R7 no pulse", cnt, 0);
        check("R7 core2 power", core_power, 3'b110);
        check("R7 start addr", boot_addr[63:32], model[10]);
        do_read(12'h0, rd);
        check("R7 bit cleared", rd, cur);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule